// File: doc/BRIEF.md
# Register-Mapped Serial Port with Byte Queues

This block is a serial transmitter and receiver that sits on a simple 32-bit register bus with single-cycle reads and writes. Software places bytes into a transmit queue and the block sends each one on the serial output as an 8N1 frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The receiver watches the serial input, checks each start bit, samples the data bits near their centres and stores each good byte in a receive queue. Software then reads the bytes from that queue.

One control word holds several fields. It has separate enables for the two directions and a mask for each of two level interrupts. It also holds two flush bits that clear themselves and a 16-bit divisor, which sets how many clock cycles each bit lasts. A status word reports whether each queue is full or empty and whether each direction is idle. The single interrupt output is the OR of the two unmasked conditions.

Top module: `uart_mmio`

## Requirements
- R1: After reset the control word (byte offset 0x0) reads 0x00D90000, which is divisor 217 with everything else off. The status word (offset 0x4) reads 0x3C. The serial output is high and the interrupt output is low.
- R2: Control bits are tx enable in bit 0, rx enable in bit 1, tx-empty interrupt mask in bit 2 and rx-not-empty interrupt mask in bit 3. The divisor sits in bits 31:16. All of these read back as written. Bits 4 and 5 are flush strobes and always read as 0.
- R3: With tx enabled, each queued byte leaves as a frame in this order: a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts exactly divisor clock cycles, and the divisor must be at least 2. With tx disabled the output stays high and the queue is not drained.
- R4: The transmit queue holds 8 bytes, written through bits 7:0 at offset 0x8. A write to a full queue drops the byte. Status bit 0 means tx full and status bit 2 means tx empty.
- R5: The receiver stores each frame it accepts in an 8-entry queue. A read at offset 0xC returns the oldest byte in bits 7:0 and removes it from the queue. A read of an empty queue returns 0 and changes nothing. Status bit 1 means rx full and status bit 3 means rx empty.
- R6: A frame that completes while the receive queue is full is thrown away. With rx disabled the receiver ignores the serial input and stays idle.
- R7: Writing 1 to control bit 4 empties the transmit queue, and writing 1 to bit 5 empties the receive queue. Each takes effect within one cycle.
- R8: The interrupt output is high when bit 2 is set and the transmit queue is empty, or when bit 3 is set and the receive queue holds data. It is low otherwise.
- R9: Status bit 4 is high unless a frame is being sent. Status bit 5 is high unless a frame is being received.
- R10: The receiver confirms a start bit half a bit time after the falling edge. A low pulse shorter than that is rejected and no byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 4 | Byte offset; bits 3:2 select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the access |
| tx_o | output | 1 | Serial output |
| rx_i | input | 1 | Serial input |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench uses the default queue depth of 8 and the reset divisor width of 16 bits. It then programs divisors between 4 and 12 so that whole frames fit in a few hundred cycles. A depth of 8 lets the bench reach both a full transmit queue and a full receive queue with only nine bytes, so the drop-on-full and discard-on-full paths are both exercised. When the serial output is fed back to the input, random byte bursts run through both directions at several divisors. This also covers back-to-back frames and odd divisors, where the half-bit point rounds down.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DIV_W  = 16;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_TXD  = 2'd2;
  localparam logic [1:0] SEL_RXD  = 2'd3;

  localparam int unsigned CTL_TX_EN    = 0;
  localparam int unsigned CTL_RX_EN    = 1;
  localparam int unsigned CTL_TXE_IE   = 2;
  localparam int unsigned CTL_RXNE_IE  = 3;
  localparam int unsigned CTL_TX_FLUSH = 4;
  localparam int unsigned CTL_RX_FLUSH = 5;
  localparam int unsigned CTL_DIV_LSB  = 16;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (full_o && $stable(wr_ptr_q)));
  assert_empty_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> (empty_o && $stable(rd_ptr_q)));
  assert_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
  import uart_mmio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              fifo_empty_i,
  input  logic [BYTE_W-1:0] fifo_data_i,
  output logic              pop_o,
  output logic              tx_o,
  output logic              idle_o
);
  localparam int unsigned FRAME_W = BYTE_W + 2;
  localparam int unsigned BIT_CW  = $clog2(FRAME_W);

  logic               busy_q;
  logic [FRAME_W-1:0] shift_q;
  logic [BIT_CW-1:0]  bit_q;
  logic [DIV_W-1:0]   div_cnt_q;
  logic               bit_end;

  assign pop_o   = !busy_q && en_i && !fifo_empty_i;
  assign tx_o    = busy_q ? shift_q[0] : 1'b1;
  assign idle_o  = !busy_q;
  assign bit_end = (div_cnt_q == div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      shift_q   <= '1;
      bit_q     <= '0;
      div_cnt_q <= '0;
    end else if (pop_o) begin
      busy_q    <= 1'b1;
      shift_q   <= {1'b1, fifo_data_i, 1'b0};
      bit_q     <= '0;
      div_cnt_q <= '0;
    end else if (busy_q) begin
      if (bit_end) begin
        div_cnt_q <= '0;
        shift_q   <= {1'b1, shift_q[FRAME_W-1:1]};
        bit_q     <= bit_q + 1'b1;
        if (bit_q == BIT_CW'(FRAME_W - 1)) busy_q <= 1'b0;
      end else begin
        div_cnt_q <= div_cnt_q + 1'b1;
      end
    end
  end

  assert_bit_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && div_cnt_q != '0) |-> $stable(tx_o));
  assert_no_start_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !en_i) |=> !busy_q);
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_mmio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rx_i,
  output logic              push_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              idle_o
);
  localparam int unsigned BIT_CW = $clog2(BYTE_W);

  rx_state_e          state_q;
  logic [1:0]         sync_q;
  logic               line;
  logic [DIV_W-1:0]   cnt_q;
  logic [DIV_W-1:0]   half_m1;
  logic [BIT_CW-1:0]  bit_q;
  logic [BYTE_W-1:0]  shift_q;
  logic               push_q;

  assign line    = sync_q[1];
  assign half_m1 = (div_i >> 1) - 1'b1;
  assign push_o  = push_q;
  assign data_o  = shift_q;
  assign idle_o  = (state_q == RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      push_q  <= 1'b0;
    end else begin
      push_q <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else begin
        unique case (state_q)
          RX_IDLE: if (!line) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
          RX_START: if (cnt_q == half_m1) begin
            state_q <= line ? RX_IDLE : RX_DATA;  // reject short glitches
            cnt_q   <= '0;
            bit_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
          RX_DATA: if (cnt_q == div_i - 1'b1) begin
            cnt_q   <= '0;
            shift_q <= {line, shift_q[BYTE_W-1:1]};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == BIT_CW'(BYTE_W - 1)) state_q <= RX_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          RX_STOP: if (cnt_q == div_i - 1'b1) begin
            state_q <= RX_IDLE;
            push_q  <= line;  // framing error drops the byte
          end else cnt_q <= cnt_q + 1'b1;
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assert_rx_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == RX_IDLE && !push_o));
  assert_push_after_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> ($past(state_q) == RX_STOP && state_q == RX_IDLE));
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_mmio_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DIV_RESET  = 217
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             tx_o,
  input  logic             rx_i,
  output logic             irq_o
);
  logic             tx_en_q, rx_en_q, txe_ie_q, rxne_ie_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       sel;
  logic             wr_ctrl, wr_txd, rd_rxd, tx_flush, rx_flush;
  logic             tx_full, tx_empty, rx_full, rx_empty, tx_idle, rx_idle;
  logic             tx_pop, rx_push;
  logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
  logic             unused_wdata;

  assign sel      = addr_i[3:2];
  assign wr_ctrl  = req_i && we_i && (sel == SEL_CTRL);
  assign wr_txd   = req_i && we_i && (sel == SEL_TXD);
  assign rd_rxd   = req_i && !we_i && (sel == SEL_RXD);
  assign tx_flush = wr_ctrl && wdata_i[CTL_TX_FLUSH];
  assign rx_flush = wr_ctrl && wdata_i[CTL_RX_FLUSH];
  assign unused_wdata = ^{wdata_i[CTL_DIV_LSB-1:CTL_RX_FLUSH+1], addr_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      txe_ie_q  <= 1'b0;
      rxne_ie_q <= 1'b0;
      div_q     <= DIV_W'(DIV_RESET);
    end else if (wr_ctrl) begin
      tx_en_q   <= wdata_i[CTL_TX_EN];
      rx_en_q   <= wdata_i[CTL_RX_EN];
      txe_ie_q  <= wdata_i[CTL_TXE_IE];
      rxne_ie_q <= wdata_i[CTL_RXNE_IE];
      div_q     <= wdata_i[CTL_DIV_LSB +: DIV_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CTRL: rdata_o = {div_q, 12'd0, rxne_ie_q, txe_ie_q, rx_en_q, tx_en_q};
      SEL_STAT: rdata_o = {26'd0, rx_idle, tx_idle, rx_empty, tx_empty, rx_full, tx_full};
      SEL_RXD:  rdata_o = rx_empty ? '0 : {24'd0, rx_head};
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = (txe_ie_q && tx_empty) || (rxne_ie_q && !rx_empty);

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(tx_flush), .push_i(wr_txd), .wdata_i(wdata_i[BYTE_W-1:0]),
    .pop_i(tx_pop), .rdata_o(tx_head), .full_o(tx_full), .empty_o(tx_empty));

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_push), .wdata_i(rx_byte),
    .pop_i(rd_rxd), .rdata_o(rx_head), .full_o(rx_full), .empty_o(rx_empty));

  uart_tx_ser u_tx (
    .clk_i, .rst_ni, .en_i(tx_en_q), .div_i(div_q), .fifo_empty_i(tx_empty),
    .fifo_data_i(tx_head), .pop_o(tx_pop), .tx_o(tx_o), .idle_o(tx_idle));

  uart_rx_deser u_rx (
    .clk_i, .rst_ni, .en_i(rx_en_q), .div_i(div_q), .rx_i(rx_i),
    .push_o(rx_push), .data_o(rx_byte), .idle_o(rx_idle));

  assert_flush_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (rdata_o[CTL_RX_FLUSH:CTL_TX_FLUSH] == 2'b00 || sel != SEL_CTRL));
  assert_irq_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txe_ie_q && !rxne_ie_q) |-> !irq_o);
endmodule

// File: tb/sim_uart_mmio.sv
module sim_uart_mmio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx, irq, rx, rx_drv = 1'b1, loop = 1'b0;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;
  assign rx = loop ? tx : rx_drv;

  uart_mmio u0 (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_o(tx), .rx_i(rx), .irq_o(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act %0d exp below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] ctl(int div, logic [5:0] bits);
    return {div[15:0], 10'd0, bits};
  endfunction
  function automatic logic [31:0] stat(bit txf, bit rxf, bit txe, bit rxe, bit txi, bit rxi);
    return {26'd0, rxi, txi, rxe, txe, rxf, txf};
  endfunction

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a; #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_byte(logic [7:0] b, int div);
    logic [9:0] fr = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_drv = fr[i];
      wait_cyc(div);
    end
    rx_drv = 1'b1;
  endtask

  logic [31:0] v;
  logic [7:0]  q [8];

  initial begin
    void'($urandom(32'd4242));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    rd(4'h0, v); chk("R1 ctrl", v, 32'h00D9_0000);
    rd(4'h4, v); chk("R1 status", v, 32'h3C);
    chk("R1 tx", {31'd0, tx}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    wr(4'h0, ctl(8, 6'b00_0001));
    rd(4'h0, v); chk("R2 readback", v, ctl(8, 6'b00_0001));
    wr(4'h0, ctl(8, 6'b00_0101));
    chk("R8 tx empty irq", {31'd0, irq}, 32'd1);
    wr(4'h0, ctl(8, 6'b00_0001));
    chk("R8 irq masked", {31'd0, irq}, 32'd0);

    // R4: fill with tx off, ninth byte dropped
    wr(4'h0, ctl(8, 6'b00_0000));
    for (int i = 0; i < 9; i++) wr(4'h8, 32'hA0 + i);
    rd(4'h4, v); chk("R4 tx full", v, stat(1, 0, 0, 1, 1, 1));
    chk("R3 tx held high when off", {31'd0, tx}, 32'd1);
    wr(4'h0, ctl(8, 6'b01_0000));
    rd(4'h4, v); chk("R7 tx flush", v, 32'h3C);
    rd(4'h0, v); chk("R2 flush bits read 0", v, ctl(8, 6'b00_0000));

    // R3 frame shape and timing, byte 0xA5
    wr(4'h0, ctl(8, 6'b00_0001));
    wr(4'h8, 32'hA5);
    begin
      int lim = 0, lo = 0;
      logic [7:0] got;
      while (tx && lim < 100) begin @(negedge clk); lim++; end
      while (!tx && lo < 100) begin @(negedge clk); lo++; end
      chk("R3 start bit length", lo, 8);
      for (int i = 0; i < 8; i++) begin
        got[i] = tx;
        wait_cyc(8);
      end
      chk("R3 data lsb first", {24'd0, got}, 32'hA5);
      chk("R3 stop bit", {31'd0, tx}, 32'd1);
    end
    wait_cyc(20);

    // R9 tx idle flag
    wr(4'h8, 32'hFF);
    wait_cyc(20);
    rd(4'h4, v); chk("R9 tx busy", v, stat(0, 0, 1, 1, 0, 1));
    wait_cyc(100);
    rd(4'h4, v); chk("R9 tx idle again", v, 32'h3C);

    // R5/R8 directed receive
    wr(4'h0, ctl(8, 6'b00_1010));
    drive_byte(8'h3C, 8);
    wait_cyc(10);
    rd(4'h4, v); chk("R5 rx not empty", v, stat(0, 0, 1, 0, 1, 1));
    chk("R8 rx irq", {31'd0, irq}, 32'd1);
    rd(4'hC, v); chk("R5 rx data", v, 32'h3C);
    chk("R8 rx irq clears", {31'd0, irq}, 32'd0);
    rd(4'hC, v); chk("R5 empty read", v, 32'h0);
    rd(4'h4, v); chk("R5 empty read no change", v, 32'h3C);

    // R10 short low pulse
    rx_drv = 0; wait_cyc(2); rx_drv = 1;
    wait_cyc(100);
    rd(4'h4, v); chk("R10 glitch rejected", v, 32'h3C);

    // R6 rx disabled
    wr(4'h0, ctl(8, 6'b00_0000));
    drive_byte(8'h77, 8);
    wait_cyc(10);
    rd(4'h4, v); chk("R6 rx off ignored", v, 32'h3C);

    // R6 discard when rx full, via loopback
    loop = 1'b1;
    wr(4'h0, ctl(8, 6'b00_0010));
    for (int i = 0; i < 9; i++) wr(4'h8, i);
    rd(4'h4, v); chk("R4 full before drain", v, stat(1, 0, 0, 1, 1, 1));
    wr(4'h0, ctl(8, 6'b00_0011));
    wait_cyc(900);
    rd(4'h4, v); chk("R6 rx full", v, stat(0, 1, 1, 0, 1, 1));
    wr(4'h8, 32'h55);
    wait_cyc(150);
    rd(4'h4, v); chk("R6 still full", v, stat(0, 1, 1, 0, 1, 1));
    for (int i = 0; i < 8; i++) begin
      rd(4'hC, v); chk("R6 kept order", v, i);
    end
    rd(4'hC, v); chk("R6 extra byte discarded", v, 32'h0);

    // R7 rx flush
    wr(4'h8, 32'h12);
    wait_cyc(150);
    wr(4'h0, ctl(8, 6'b10_0011));
    rd(4'h4, v); chk("R7 rx flush", v, 32'h3C);

    // random loopback bursts (R3, R5)
    for (int r = 0; r < 12; r++) begin
      int div = 4 + ($urandom % 9);
      int n   = 1 + ($urandom % 8);
      wr(4'h0, ctl(div, 6'b11_0011));
      for (int i = 0; i < n; i++) begin
        q[i] = 8'($urandom);
        wr(4'h8, {24'd0, q[i]});
      end
      wait_cyc((n * 10 + 4) * (div + 1));
      for (int i = 0; i < n; i++) begin
        rd(4'hC, v); chk("R5 loopback byte", v, {24'd0, q[i]});
      end
      rd(4'h4, v); chk("R3 loopback drained", v, 32'h3C);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule